// File: doc/BRIEF.md
# 8-bit Arithmetic and Flag Unit

This block is a purely combinational arithmetic and logic unit for a small 8-bit processor datapath. It receives a left operand, a right operand, a carry/borrow input and a 3-bit function code. It returns an 8-bit result together with five condition outputs: carry (or borrow), half carry out of bit 3, zero, sign and even parity.

Eight functions are provided: four arithmetic ones (plus, plus with carry, minus, minus with borrow), three bitwise ones (AND, XOR, OR) and a compare. Compare forms the difference only for its flags and passes the left operand through as the result. The surrounding core owns the flag register and decides which flags to keep. The outputs follow the inputs in the same cycle.

Top module: `alu8_core`

## Requirements
- R1: The function code `fn_sel` selects: 000 plus, 001 plus with carry, 010 minus, 011 minus with borrow, 100 AND, 101 XOR, 110 OR, 111 compare.
- R2: For plus (000), `{cy_o, res_o}` equals `opa_i + opb_i` as a 9-bit sum.
- R3: For plus with carry (001), `{cy_o, res_o}` equals `opa_i + opb_i + cin_i`.
- R4: For minus (010), `res_o` is `opa_i - opb_i` modulo 256, and `cy_o` is 1 exactly when `opb_i > opa_i`.
- R5: For minus with borrow (011), `res_o` is `opa_i - opb_i - cin_i` modulo 256, and `cy_o` is 1 exactly when `opb_i + cin_i > opa_i`.
- R6: `hc_o` is the carry out of bit 3 for the plus functions, and for the minus functions and compare it is 1 exactly when the low nibble of `opb_i` plus the borrow used is greater than the low nibble of `opa_i`.
- R7: For AND, XOR and OR, `res_o` is the bitwise function of the operands, and `cy_o` and `hc_o` are both 0.
- R8: For compare (111), `res_o` equals `opa_i`, while `cy_o` and `hc_o` are those of minus (010).
- R9: `zf_o` is 1 exactly when the result is zero and `sf_o` equals result bit 7. For compare, the result used is the difference `opa_i - opb_i`.
- R10: `pf_o` is 1 exactly when the result (the difference for compare) has an even number of one bits.
- R11: `cin_i` has no effect on any output for functions 000, 010, 100, 101, 110 and 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 8 | Left operand |
| opb_i | input | 8 | Right operand |
| cin_i | input | 1 | Carry in (001) or borrow in (011) |
| fn_sel | input | 3 | Function code |
| res_o | output | 8 | Result |
| cy_o | output | 1 | Carry out, or borrow for minus and compare |
| hc_o | output | 1 | Half carry or borrow at bit 3 |
| zf_o | output | 1 | Zero |
| sf_o | output | 1 | Sign |
| pf_o | output | 1 | Even parity |

## Verification
The bound checker tests the following in every evaluation: the 9-bit sum for plus, that the bitwise functions clear both carry outputs, that compare passes the left operand through, and the zero and parity relations between the result and the flags for the non-compare functions. Borrow and half borrow for the minus functions, the effect of the carry input on the carry-using functions, its lack of effect on the other functions, and the compare flags taken from the hidden difference are shown only by the bench. The bench has directed scenarios at the carry and borrow boundaries, plus a sweep of pseudo-random operands compared against an integer reference model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        FN_ADD = 3'b000,
        FN_ADC = 3'b001,
        FN_SUB = 3'b010,
        FN_SBB = 3'b011,
        FN_AND = 3'b100,
        FN_XOR = 3'b101,
        FN_OR  = 3'b110,
        FN_CMP = 3'b111
    } fn_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_XOR = 2'd1,
        LG_OR  = 2'd2
    } lg_e;

    typedef struct packed {
        logic is_logic;
        logic do_sub;
        logic use_cin;
        logic keep_a;
        lg_e  lg_op;
    } ctl_t;

    function automatic ctl_t decode_fn(input fn_e f);
        ctl_t c;
        c.is_logic = 1'b0;
        c.do_sub   = 1'b0;
        c.use_cin  = 1'b0;
        c.keep_a   = 1'b0;
        c.lg_op    = LG_AND;
        unique case (f)
            FN_ADD: ;
            FN_ADC: c.use_cin = 1'b1;
            FN_SUB: c.do_sub = 1'b1;
            FN_SBB: begin c.do_sub = 1'b1; c.use_cin = 1'b1; end
            FN_AND: begin c.is_logic = 1'b1; c.lg_op = LG_AND; end
            FN_XOR: begin c.is_logic = 1'b1; c.lg_op = LG_XOR; end
            FN_OR:  begin c.is_logic = 1'b1; c.lg_op = LG_OR; end
            FN_CMP: begin c.do_sub = 1'b1; c.keep_a = 1'b1; end
            default: ;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8,
    parameter int H = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cb_in,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         h_out
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HW = W - H;

    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [H:0]    lo;
    logic [HW:0]   hi;

    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cb_in : cb_in;
        lo    = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c_eff};
        hi    = {1'b0, a[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{HW{1'b0}}, lo[H]};
        sum   = {hi[HW-1:0], lo[H-1:0]};
        c_out = sub ? ~hi[HW] : hi[HW];
        h_out = sub ? ~lo[H] : lo[H];
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  lg_e          op,
    output logic [W-1:0] y
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (op)
                LG_AND:  y[i] = a[i] & b[i];
                LG_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = a[i] | b[i];
            endcase
        end
    end
endmodule

// File: rtl/alu8_flagset.sv
module alu8_flagset #(
    parameter int W = 8
) (
    input  logic [W-1:0] v,
    output logic         zero,
    output logic         sign,
    output logic         even
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W:0] chain;
    assign chain[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_par
        assign chain[i+1] = chain[i] ^ v[i];
    end

    assign zero = (v == '0);
    assign sign = v[W-1];
    assign even = chain[W];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8,
    parameter int H = 4
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         cin_i,
    input  logic [2:0]   fn_sel,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         hc_o,
    output logic         zf_o,
    output logic         sf_o,
    output logic         pf_o
);
    timeunit 1ns;
    timeprecision 1ps;

    ctl_t         ctl;
    logic [W-1:0] arith_y;
    logic [W-1:0] logic_y;
    logic [W-1:0] flag_src;
    logic         a_cy;
    logic         a_hc;

    assign ctl = decode_fn(fn_e'(fn_sel));

    alu8_addsub #(.W(W), .H(H)) addsub_i (
        .a     (opa_i),
        .b     (opb_i),
        .cb_in (cin_i & ctl.use_cin),
        .sub   (ctl.do_sub),
        .sum   (arith_y),
        .c_out (a_cy),
        .h_out (a_hc)
    );

    alu8_bitwise #(.W(W)) bitwise_i (
        .a  (opa_i),
        .b  (opb_i),
        .op (ctl.lg_op),
        .y  (logic_y)
    );

    assign flag_src = ctl.is_logic ? logic_y : arith_y;
    assign res_o    = ctl.keep_a ? opa_i : flag_src;
    assign cy_o     = ctl.is_logic ? 1'b0 : a_cy;
    assign hc_o     = ctl.is_logic ? 1'b0 : a_hc;

    alu8_flagset #(.W(W)) flagset_i (
        .v    (flag_src),
        .zero (zf_o),
        .sign (sf_o),
        .even (pf_o)
    );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [2:0]   fn_sel,
    input logic [W-1:0] res_o,
    input logic         cy_o,
    input logic         hc_o,
    input logic         zf_o,
    input logic         pf_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W:0] wide_sum;
    assign wide_sum = {1'b0, opa_i} + {1'b0, opb_i};

    always_comb begin
        if (fn_sel == 3'b000)
            p_add_sum_r2: assert ({cy_o, res_o} == wide_sum);
        if (fn_sel[2] && fn_sel != 3'b111)
            p_logic_clears_r7: assert (!cy_o && !hc_o);
        if (fn_sel == 3'b111)
            p_cmp_keeps_a_r8: assert (res_o == opa_i);
        if (fn_sel != 3'b111)
            p_zero_flag_r9: assert (zf_o == (res_o == '0));
        if (fn_sel != 3'b111)
            p_even_parity_r10: assert (pf_o == ($countones(res_o) % 2 == 0));
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) chk_i (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .fn_sel (fn_sel),
    .res_o  (res_o),
    .cy_o   (cy_o),
    .hc_o   (hc_o),
    .zf_o   (zf_o),
    .pf_o   (pf_o)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic [7:0] opa, opb;
    logic       cin;
    logic [2:0] fsel;
    logic [7:0] res;
    logic       cy, hc, zf, sf, pf;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    alu8_core dut_i (
        .opa_i (opa), .opb_i (opb), .cin_i (cin), .fn_sel (fsel),
        .res_o (res), .cy_o (cy), .hc_o (hc), .zf_o (zf), .sf_o (sf), .pf_o (pf)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Reference model, integer arithmetic from the requirements.
    function automatic logic [12:0] model(input int a, input int b, input int c, input int f);
        int r, cyv, hcv, bin, d, pc, dres;
        cyv = 0; hcv = 0; r = 0;
        case (f)
            0, 1: begin
                bin = (f == 1) ? c : 0;
                r = a + b + bin;
                cyv = (r > 255) ? 1 : 0;
                hcv = ((a % 16) + (b % 16) + bin > 15) ? 1 : 0;
                r = r % 256;
            end
            2, 3, 7: begin
                bin = (f == 3) ? c : 0;
                d = a - b - bin;
                cyv = (d < 0) ? 1 : 0;
                hcv = ((a % 16) - (b % 16) - bin < 0) ? 1 : 0;
                r = (d + 512) % 256;
            end
            4: r = a & b;
            5: r = a ^ b;
            default: r = a | b;
        endcase
        dres = r;
        pc = 0;
        for (int i = 0; i < 8; i++) pc += (dres >> i) & 1;
        if (f == 7) r = a;
        return {r[7:0], cyv[0], hcv[0], (dres == 0) ? 1'b1 : 1'b0,
                dres[7], (pc % 2 == 0) ? 1'b1 : 1'b0};
    endfunction

    task automatic apply_chk(input string tag, input int a, input int b,
                             input int c, input int f);
        logic [12:0] exp_v, got_v;
        @(negedge clk);
        opa = a[7:0]; opb = b[7:0]; cin = c[0]; fsel = f[2:0];
        @(posedge clk);
        #1;
        exp_v = model(a, b, c, f);
        got_v = {res, cy, hc, zf, sf, pf};
        n_chk++;
        if (got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: f=%0d a=%02h b=%02h c=%0d got {res,cy,hc,z,s,p}=%h expected %h",
                     tag, f, a, b, c, got_v, exp_v);
        end
    endtask

    task automatic t_idle_state();
        apply_chk("R9 R10 all-zero inputs", 0, 0, 0, 0);
    endtask

    task automatic t_add();
        apply_chk("R2 plus", 8'h12, 8'h34, 0, 0);
        apply_chk("R2 R6 plus nibble carry", 8'h0F, 8'h01, 0, 0);
        apply_chk("R2 R9 plus wrap to zero", 8'hFF, 8'h01, 0, 0);
        apply_chk("R3 plus with carry", 8'hFE, 8'h01, 1, 1);
        apply_chk("R3 plus with carry 0", 8'h7F, 8'h00, 0, 1);
        apply_chk("R3 R6 carry into nibble", 8'h0F, 8'h00, 1, 1);
    endtask

    task automatic t_sub();
        apply_chk("R4 minus", 8'h50, 8'h20, 0, 2);
        apply_chk("R4 minus borrow", 8'h20, 8'h21, 0, 2);
        apply_chk("R4 R9 minus equal", 8'h33, 8'h33, 0, 2);
        apply_chk("R6 half borrow", 8'h10, 8'h01, 0, 2);
        apply_chk("R5 minus with borrow", 8'h05, 8'h04, 1, 3);
        apply_chk("R5 borrow boundary", 8'h05, 8'h05, 1, 3);
        apply_chk("R5 borrow 0", 8'h05, 8'h05, 0, 3);
    endtask

    task automatic t_logic();
        apply_chk("R7 AND", 8'hF0, 8'h3C, 0, 4);
        apply_chk("R7 XOR", 8'hAA, 8'hAA, 0, 5);
        apply_chk("R7 OR", 8'h81, 8'h02, 0, 6);
        apply_chk("R1 R7 AND of all ones", 8'hFF, 8'hFF, 0, 4);
    endtask

    task automatic t_cmp();
        apply_chk("R8 compare equal", 8'h42, 8'h42, 0, 7);
        apply_chk("R8 compare below", 8'h01, 8'h02, 0, 7);
        apply_chk("R8 R9 compare sign", 8'h00, 8'h01, 0, 7);
    endtask

    task automatic t_cin_ignored();
        for (int f = 0; f < 8; f++) begin
            if (f == 1 || f == 3) continue;
            apply_chk("R11 cin ignored", 8'h9B, 8'h6E, 1, f);
        end
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply_chk("R1 sweep", int'(lfsr[7:0]), int'(lfsr[15:8]),
                      int'(lfsr[3]), k % 8);
        end
    endtask

    initial begin
        opa = '0; opb = '0; cin = 1'b0; fsel = '0;
        repeat (2) @(posedge clk);
        t_idle_state();
        t_add();
        t_sub();
        t_logic();
        t_cmp();
        t_cin_ignored();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule